// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is a byte-wide general-purpose I/O port. Three read/write registers sit on a simple byte register bus: an output data latch, a per-bit direction mask and a per-bit pull-up request mask. From these registers the block drives an output-enable, an output value and a pull-up request for each pad. It also takes in the raw level of each pad.

Each pad level passes through a two-stage synchroniser before the read path sees it. A read of the data register returns a per-bit mix: output bits show the latch and input bits show the synchronised pad level. A pull-up is granted only to a bit that is an input. Setting a direction bit removes that bit's pull-up on the next clock edge, with no further register write. Software sees a conventional port. The block makes sure a pad is never driven and pulled up at the same time.

Top module: `gpio_port_ctrl`

## Requirements
- R1: The data latch is at address 0x03, the direction mask at 0x07 and the pull-up mask at 0x0F. A write with `bus_we` high updates the addressed register on that clock edge. The direction and pull-up masks read back exactly the value last written.
- R2: While `rst` is high at a clock edge, all three registers and the synchroniser clear to zero. After that edge `pad_oe`, `pad_out` and `pad_pu` are all zero and every pin is an undriven input.
- R3: A direction bit of 1 sets that bit of `pad_oe` to 1 and makes that bit of `pad_out` equal to the latch bit. A direction bit of 0 sets both `pad_oe` and `pad_out` to 0 for that bit.
- R4: Each bit of `pad_pu` is 1 only when its pull-up mask bit is 1 and its direction bit is 0. It drops on the same edge that sets the direction bit.
- R5: An input bit whose pull-up mask bit is 0 floats: `pad_oe`, `pad_out` and `pad_pu` are all 0 for that bit.
- R6: A read of address 0x03 returns, in each bit, the latch value where the direction bit is 1 and the synchronised pad level where it is 0.
- R7: A write to the data latch stores every bit, inputs included. The stored value does not change what input bits read back. It appears on the pad once the bit is switched to output.
- R8: For input bits, the value read at 0x03 equals the `pad_in` value sampled two clock edges earlier.
- R9: A read of any address other than 0x03, 0x07 or 0x0F returns zero.
- R10: With `bus_we` low, no register changes, whatever the address and write data are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable, acts on the clock edge |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-pad output-driver enable |
| pad_out | output | 8 | Per-pad output value |
| pad_pu | output | 8 | Per-pad pull-up request |

## Verification
The bench builds the block with its default parameters: an 8-bit port, an 8-bit address space, register offsets 0x03, 0x07 and 0x0F, and two synchroniser stages. With an 8-bit address, all 256 addresses can be swept, so every unmapped address gets a check for a zero read. With two stages, the bench can observe the exact edge on which a new pad level first reaches the read path. Mixed direction and pull-up patterns cover the per-bit selection between latch and pad and the gating of pull-ups on output bits.

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int          WIDTH       = 8,
  parameter int          ADDR_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  DATA_OFS    = 8'h03,
  parameter logic [7:0]  DIR_OFS     = 8'h07,
  parameter logic [7:0]  PU_OFS      = 8'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_pu
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(DIR_OFS);
  localparam logic [ADDR_W-1:0] A_PU   = ADDR_W'(PU_OFS);

  logic [WIDTH-1:0] latch_q, dir_q, pue_q;
  logic [WIDTH-1:0] sync_q [SYNC_STAGES];
  logic [WIDTH-1:0] pin_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
      pue_q   <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_DATA) latch_q <= bus_wdata;
      if (bus_addr == A_DIR)  dir_q   <= bus_wdata;
      if (bus_addr == A_PU)   pue_q   <= bus_wdata;
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst)         sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= pad_in;
      else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  assign pin_s   = sync_q[SYNC_STAGES-1];
  assign pad_oe  = dir_q;
  assign pad_out = latch_q & dir_q;
  assign pad_pu  = pue_q & ~dir_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_DATA)     bus_rdata = (latch_q & dir_q) | (pin_s & ~dir_q);
    else if (bus_addr == A_DIR) bus_rdata = dir_q;
    else if (bus_addr == A_PU)  bus_rdata = pue_q;
  end

  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)                warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  assert_reset_quiet_R2: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_pu == '0 && pad_out == '0));

  assert_dir_write_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_DIR) |=> pad_oe == $past(bus_wdata));

  assert_pu_gated_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_DIR) |=> (pad_pu & pad_oe) == '0);

  assert_out_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ~pad_oe) == '0);

  assert_mix_out_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_DATA) |-> (bus_rdata & pad_oe) == pad_out);

  assert_sync_lag_R8: assert property (@(posedge clk) disable iff (rst)
    (warm_q >= 2'd2 && bus_addr == A_DATA) |->
      ((bus_rdata ^ $past(pad_in, 2)) & ~pad_oe) == '0);

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != A_DATA && bus_addr != A_DIR && bus_addr != A_PU) |-> bus_rdata == '0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!bus_we && warm_q != 2'd0) |=>
      ($stable(pad_oe) && $stable(pad_pu) && $stable(pad_out)));

endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] bus_addr, bus_wdata, bus_rdata, pad_in, pad_oe, pad_out, pad_pu;
  logic       bus_we;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #10 clk = ~clk;

  gpio_port_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  // dir, pull-up mask, latch, pad level
  localparam logic [31:0] VEC [8] = '{
    32'h00_FF_00_A5, 32'hFF_FF_3C_00, 32'h0F_F0_AA_55, 32'hF0_FF_5A_0F,
    32'h81_7E_C3_3C, 32'h55_AA_FF_00, 32'hAA_55_00_FF, 32'h3C_C3_99_66
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; pad_in = '0;
    repeat (3) @(negedge clk);
    chk("R2 oe", pad_oe, 8'h00);
    chk("R2 pu", pad_pu, 8'h00);
    chk("R2 out", pad_out, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    rd(8'h07, r); chk("R2 dir", r, 8'h00);
    rd(8'h0F, r); chk("R2 pue", r, 8'h00);
    rd(8'h03, r); chk("R2 data", r, 8'h00);

    for (int i = 0; i < 8; i++) begin
      logic [7:0] d, p, l, n;
      {d, p, l, n} = VEC[i];
      pad_in = n;
      wr(8'h0F, p); wr(8'h03, l); wr(8'h07, d);
      repeat (2) @(negedge clk);
      chk("R3 oe", pad_oe, d);
      chk("R3 out", pad_out, l & d);
      chk("R4 pu", pad_pu, p & ~d);
      chk("R5 float", (pad_oe | pad_pu | pad_out) & ~d & ~p, 8'h00);
      rd(8'h03, r); chk("R6 data", r, (l & d) | (n & ~d));
      rd(8'h07, r); chk("R1 dir", r, d);
      rd(8'h0F, r); chk("R1 pue", r, p);
    end

    // R4: pull-up removed on the edge that makes the bit an output
    wr(8'h07, 8'h00); wr(8'h0F, 8'hFF);
    chk("R4 pre", pad_pu, 8'hFF);
    wr(8'h07, 8'h0F);
    chk("R4 gate", pad_pu, 8'hF0);

    // R7: latch written while inputs, readback unaffected, driven later
    wr(8'h07, 8'h00); pad_in = 8'h00;
    repeat (2) @(negedge clk);
    wr(8'h03, 8'hC6);
    rd(8'h03, r); chk("R7 in readback", r, 8'h00);
    chk("R7 not driven", pad_out, 8'h00);
    wr(8'h07, 8'hFF);
    chk("R7 drive", pad_out, 8'hC6);
    rd(8'h03, r); chk("R7 latch read", r, 8'hC6);

    // R8: two-edge lag
    wr(8'h07, 8'h00); pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'h5A;
    @(negedge clk);
    rd(8'h03, r); chk("R8 one edge", r, 8'h00);
    @(negedge clk);
    rd(8'h03, r); chk("R8 two edges", r, 8'h5A);

    // R10: write-enable low
    wr(8'h07, 8'h33); wr(8'h0F, 8'h44); wr(8'h03, 8'h55);
    @(negedge clk);
    bus_we = 1'b0;
    foreach (VEC[k]) begin
      bus_addr = (k % 3 == 0) ? 8'h03 : (k % 3 == 1) ? 8'h07 : 8'h0F;
      bus_wdata = ~VEC[k][7:0];
      @(negedge clk);
    end
    rd(8'h07, r); chk("R10 dir", r, 8'h33);
    rd(8'h0F, r); chk("R10 pue", r, 8'h44);
    chk("R10 out", pad_out, 8'h55 & 8'h33);

    // R9: sweep unmapped
    for (int a = 0; a < 256; a++) begin
      if (a != 3 && a != 7 && a != 15) begin
        rd(8'(a), r); chk("R9 unmapped", r, 8'h00);
      end
    end

    // R2: mid-run reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R2 mid oe", pad_oe, 8'h00);
    chk("R2 mid pu", pad_pu, 8'h00);
    chk("R2 mid out", pad_out, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule